// File: doc/BRIEF.md
# Serial Display Loader with Latch Strobe

This block pushes a parallel word into a chain of latched 8-bit shift registers that drive a display. The chain is reached over three wires: serial data, a shift clock and a store clock. After a one-cycle start pulse the block captures an N×8-bit word. It sends the word one bit per shift-clock pulse, most-significant bit first. The first bit therefore travels through every cascade stage and ends at the last output of the register farthest from the block. Once every bit is in place, the block gives one store-clock pulse, so all display outputs change together.

The high and low times of both strobes are set in system clocks on input ports, and a setting of zero acts as one. A separate active-low output-enable line can blank the display from a static input, or toggle at a fixed rate to make it blink, with no reload of data. The controller is one finite-state machine with six states:

- **IDLE** waits for a start pulse.
- **LOW** is the low phase of the shift clock, with the current bit placed on the serial line.
- **HIGH** is the high phase of the shift clock.
- **GAP** is a low spacing after the last bit.
- **STORE** is the store-clock pulse.
- **DONE** is a one-cycle completion marker.

The transitions are:

- IDLE→LOW on start.
- LOW→HIGH when the low time expires.
- HIGH→LOW when the high time expires and bits remain, and HIGH→GAP after the last bit.
- GAP→STORE when the low time expires.
- STORE→DONE when the store time expires.
- DONE→IDLE always.

Top module: `disp_serial_loader`

## Requirements
- R1: After reset the shift clock, store clock, serial data, busy and done outputs are all 0.
- R2: A start pulse sampled while busy is 0 captures `word_in`, and busy is 1 from the next cycle until the DONE cycle ends.
- R3: Each transfer gives exactly NUM_REGS×8 shift-clock pulses. Bit k of the word goes out on pulse NUM_REGS×8−k, so the MSB goes first. The serial line changes only while the shift clock is low and holds its value across every rising edge.
- R4: Each shift-clock high phase lasts max(`sclk_hi`,1) cycles and each low phase lasts max(`sclk_lo`,1) cycles. The first low phase starts in the cycle after start is sampled.
- R5: The store clock stays low while bits are shifted. After the last shift-clock fall and a low gap of max(`sclk_lo`,1) cycles, it gives exactly one high pulse of max(`stclk_hi`,1) cycles.
- R6: Done is 1 for exactly the one cycle that follows the store pulse, and is 0 at all other times.
- R7: A start pulse that arrives while busy is 1 is ignored. The running transfer keeps its word and no second transfer follows.
- R8: After done, a chain of receivers (each bit sampled on a shift-clock rise and latched on a store-clock rise) holds the full word. The farthest register holds the top byte.
- R9: While `blink_en` is 0, `oe_n` equals `blank_in` in the same cycle.
- R10: While `blink_en` is 1, `oe_n` is 0 for BLINK_HALF cycles, then 1 for BLINK_HALF cycles, repeating. The on-phase starts again each time `blink_en` rises, and blinking has no effect on transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to send `word_in` |
| word_in | input | NUM_REGS*8 | Word to send; MSB is sent first |
| sclk_lo | input | CNT_W | Shift-clock low time in cycles (0 acts as 1) |
| sclk_hi | input | CNT_W | Shift-clock high time in cycles (0 acts as 1) |
| stclk_hi | input | CNT_W | Store-clock high time in cycles (0 acts as 1) |
| blank_in | input | 1 | Static blank request used when blinking is off |
| blink_en | input | 1 | Selects periodic blanking |
| ser_out | output | 1 | Serial data to the first register of the chain |
| shift_clk | output | 1 | Shift clock to the chain |
| store_clk | output | 1 | Store (latch) clock to the chain |
| oe_n | output | 1 | Active-low output enable for the chain |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The strobes, serial data, busy and done come from the state register, so each is due in the cycle after the edge that moves the state. Busy rises one cycle after start is sampled. Every phase length then adds exactly its programmed count, and done follows the store pulse by zero cycles as the pulse falls. The output enable is combinational on `blink_en` and `blank_in`, with a blink phase that advances on each edge. The bench drives inputs one nanosecond after a rising edge and compares every output at the falling edge against a behavioural model of phases, bit index and blink count, so each result is checked in the cycle it becomes due. A model of the receiving chain, clocked by the block's own strobes, confirms bit order and the final latched word.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

    // One-hot state codes: each strobe is decoded from a single flop.
    typedef enum logic [5:0] {
        S_IDLE  = 6'b000001,
        S_LOW   = 6'b000010,
        S_HIGH  = 6'b000100,
        S_GAP   = 6'b001000,
        S_STORE = 6'b010000,
        S_DONE  = 6'b100000
    } dsl_state_t;

endpackage

// File: rtl/dsl_phase_timer.sv
// Down counter that times one strobe phase. Loaded on entry to a phase
// with (length-1); reports expiry while the count is zero.
module dsl_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dsl_word_shifter.sv
// Holds the word being sent; presents its MSB on the serial line and
// moves left by one bit per completed shift-clock pulse.
module dsl_word_shifter #(
    parameter int NB = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NB-1:0] word,
    input  logic          adv,
    output logic          bit_out,
    output logic          last_bit
);

    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

    logic [NB-1:0]    sreg_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            sreg_q <= word;
            idx_q  <= '0;
        end else if (adv) begin
            sreg_q <= {sreg_q[NB-2:0], 1'b0};
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign bit_out  = sreg_q[NB-1];
    assign last_bit = (idx_q == IDX_W'(NB - 1));

endmodule

// File: rtl/dsl_blink.sv
// Output-enable source: follows the static blank input, or toggles every
// HALF cycles while blinking is enabled (starting in the visible phase).
module dsl_blink #(
    parameter int HALF = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blink_en,
    input  logic blank_in,
    output logic oe_n
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (!blink_en) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q == CW'(HALF - 1)) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign oe_n = blink_en ? phase_q : blank_in;

endmodule

// File: rtl/disp_serial_loader.sv
module disp_serial_loader #(
    parameter int NUM_REGS   = 2,
    parameter int CNT_W      = 8,
    parameter int BLINK_HALF = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [NUM_REGS*8-1:0]   word_in,
    input  logic [CNT_W-1:0]        sclk_lo,
    input  logic [CNT_W-1:0]        sclk_hi,
    input  logic [CNT_W-1:0]        stclk_hi,
    input  logic                    blank_in,
    input  logic                    blink_en,
    output logic                    ser_out,
    output logic                    shift_clk,
    output logic                    store_clk,
    output logic                    oe_n,
    output logic                    busy,
    output logic                    done
);

    import dsl_pkg::*;

    localparam int NB = NUM_REGS * 8;

    dsl_state_t state_q, state_d;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    logic             sh_load;
    logic             sh_adv;
    logic             sh_last;

    // Phase length minus one, with zero treated as a length of one.
    function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    dsl_phase_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    dsl_word_shifter #(.NB(NB)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .word     (word_in),
        .adv      (sh_adv),
        .bit_out  (ser_out),
        .last_bit (sh_last)
    );

    dsl_blink #(.HALF(BLINK_HALF)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .blink_en (blink_en),
        .blank_in (blank_in),
        .oe_n     (oe_n)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and datapath controls.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_adv   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d  = S_LOW;
                    sh_load  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = len_m1(sclk_lo);
                end
            end
            S_LOW: begin
                if (tmr_exp) begin
                    state_d  = S_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = len_m1(sclk_hi);
                end
            end
            S_HIGH: begin
                if (tmr_exp) begin
                    // The bit just clocked is consumed; the next one is
                    // placed while the shift clock is low again.
                    sh_adv   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = len_m1(sclk_lo);
                    state_d  = sh_last ? S_GAP : S_LOW;
                end
            end
            S_GAP: begin
                if (tmr_exp) begin
                    state_d  = S_STORE;
                    tmr_load = 1'b1;
                    tmr_val  = len_m1(stclk_hi);
                end
            end
            S_STORE: begin
                if (tmr_exp) begin
                    state_d = S_DONE;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // Moore outputs decoded from the state register.
    always_comb begin
        shift_clk = 1'b0;
        store_clk = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE:  busy      = 1'b0;
            S_LOW:   shift_clk = 1'b0;
            S_HIGH:  shift_clk = 1'b1;
            S_GAP:   shift_clk = 1'b0;
            S_STORE: store_clk = 1'b1;
            S_DONE:  done      = 1'b1;
            default: busy      = 1'b0;
        endcase
    end

endmodule

// File: rtl/dsl_loader_chk.sv
module dsl_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic ser_out,
    input logic shift_clk,
    input logic store_clk
);

    // R2
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    ser_stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_clk) |-> $stable(ser_out));

    // R5
    store_quiet_in_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_clk |-> !store_clk);

    // R5
    store_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_clk) |-> $past(!shift_clk));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_on_store_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(store_clk) |-> done);

    // R7
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind disp_serial_loader dsl_loader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .ser_out   (ser_out),
    .shift_clk (shift_clk),
    .store_clk (store_clk)
);

// File: tb/sim_disp_serial_loader.sv
module sim_disp_serial_loader;

    localparam int NR   = 2;
    localparam int NB   = NR * 8;
    localparam int CW   = 8;
    localparam int HALF = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NB-1:0] word_in = '0;
    logic [CW-1:0] sclk_lo = '0, sclk_hi = '0, stclk_hi = '0;
    logic          blank_in = 1'b0, blink_en = 1'b0;
    logic          ser_out, shift_clk, store_clk, oe_n, busy, done;

    always #2 clk = ~clk;

    disp_serial_loader #(.NUM_REGS(NR), .CNT_W(CW), .BLINK_HALF(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in),
        .sclk_lo(sclk_lo), .sclk_hi(sclk_hi), .stclk_hi(stclk_hi),
        .blank_in(blank_in), .blink_en(blink_en),
        .ser_out(ser_out), .shift_clk(shift_clk), .store_clk(store_clk),
        .oe_n(oe_n), .busy(busy), .done(done)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef enum int {M_IDLE, M_LOW, M_HIGH, M_GAP, M_STORE, M_DONE} mst_t;
    mst_t          m_st = M_IDLE;
    int            m_left = 0;
    int            m_bit = 0;
    logic [NB-1:0] m_word = '0;
    int            b_cnt = 0;
    logic          b_ph = 1'b0;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_IDLE; m_left = 0; m_bit = 0; m_word = '0;
            b_cnt = 0; b_ph = 1'b0;
        end else begin
            case (m_st)
                M_IDLE: if (start) begin
                    m_word = word_in; m_bit = 0; m_st = M_LOW; m_left = eff(int'(sclk_lo));
                end
                M_LOW: begin
                    m_left--;
                    if (m_left == 0) begin m_st = M_HIGH; m_left = eff(int'(sclk_hi)); end
                end
                M_HIGH: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_left = eff(int'(sclk_lo));
                        if (m_bit == NB - 1) m_st = M_GAP;
                        else begin m_bit++; m_st = M_LOW; end
                    end
                end
                M_GAP: begin
                    m_left--;
                    if (m_left == 0) begin m_st = M_STORE; m_left = eff(int'(stclk_hi)); end
                end
                M_STORE: begin
                    m_left--;
                    if (m_left == 0) m_st = M_DONE;
                end
                default: m_st = M_IDLE;
            endcase
            if (!blink_en) begin b_cnt = 0; b_ph = 1'b0; end
            else if (b_cnt == HALF - 1) begin b_cnt = 0; b_ph = ~b_ph; end
            else b_cnt++;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic e_ser, e_oe;
            e_ser = (m_st == M_LOW || m_st == M_HIGH) ? m_word[NB-1-m_bit] : 1'b0;
            e_oe  = blink_en ? b_ph : blank_in;
            chk(shift_clk == (m_st == M_HIGH),  "R4 shift_clk", int'(shift_clk), int'(m_st == M_HIGH));
            chk(store_clk == (m_st == M_STORE), "R5 store_clk", int'(store_clk), int'(m_st == M_STORE));
            chk(busy == (m_st != M_IDLE),       "R2 busy",      int'(busy),      int'(m_st != M_IDLE));
            chk(done == (m_st == M_DONE),       "R6 done",      int'(done),      int'(m_st == M_DONE));
            chk(ser_out == e_ser,               "R3 ser_out",   int'(ser_out),   int'(e_ser));
            chk(oe_n == e_oe, blink_en ? "R10 oe_n" : "R9 oe_n", int'(oe_n), int'(e_oe));
        end
    end

    // ---------------- receiving chain model ----------------
    logic [NB-1:0] rx_sh = '0, rx_lat = '0;
    int n_sp = 0, n_stp = 0;
    always @(posedge shift_clk) begin rx_sh <= {rx_sh[NB-2:0], ser_out}; n_sp++; end
    always @(posedge store_clk) begin rx_lat <= rx_sh; n_stp++; end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            if (done) return;
            tick();
        end
        chk(1'b0, "R6 done timeout", 0, 1);
    endtask

    task automatic send(input logic [NB-1:0] w, input int lo, input int hi, input int st);
        sclk_lo = CW'(lo); sclk_hi = CW'(hi); stclk_hi = CW'(st);
        word_in = w; start = 1'b1; n_sp = 0; n_stp = 0;
        tick();
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        wait_done();
        tick();
        chk(rx_lat == w, "R8 latched word", int'(rx_lat), int'(w));
        chk(rx_lat[NB-1 -: 8] == w[NB-1 -: 8], "R8 farthest byte", int'(rx_lat[NB-1 -: 8]), int'(w[NB-1 -: 8]));
        chk(n_sp == NB, "R3 shift pulse count", n_sp, NB);
        chk(n_stp == 1, "R5 store pulse count", n_stp, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R6 watchdog act=hung exp=finished");
            summary();
        end
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk({shift_clk, store_clk, ser_out, busy, done} == 5'b0, "R1 reset outputs",
            int'({shift_clk, store_clk, ser_out, busy, done}), 0);
        rst_n = 1'b1;
        tick();
        chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", int'({busy, done}), 0);

        // R4: zero settings act as one cycle
        send(16'hA5C3, 0, 0, 0);
        // R4/R5: longer phases
        send(16'h1234, 3, 2, 4);
        send(16'h8001, 1, 3, 2);
        send(16'hFFFF, 2, 1, 1);
        send(16'h0000, 1, 1, 3);

        // R7: start while busy is ignored
        sclk_lo = 8'd2; sclk_hi = 8'd2; stclk_hi = 8'd2;
        word_in = 16'h5AF0; start = 1'b1; n_sp = 0; n_stp = 0;
        tick();
        start = 1'b0;
        repeat (5) tick();
        word_in = 16'h0F0F; start = 1'b1;
        tick();
        start = 1'b0;
        wait_done();
        tick();
        chk(rx_lat == 16'h5AF0, "R7 busy start ignored", int'(rx_lat), 16'h5AF0);
        chk(n_sp == NB, "R7 no extra pulses", n_sp, NB);
        repeat (40) tick();
        chk(busy == 1'b0 && n_stp == 1, "R7 no second transfer", int'({busy, n_stp[0]}), 1);

        // R9: static blanking
        blank_in = 1'b1; tick();
        chk(oe_n == 1'b1, "R9 blank high", int'(oe_n), 1);
        blank_in = 1'b0; tick();
        chk(oe_n == 1'b0, "R9 blank low", int'(oe_n), 0);

        // R10: blinking, with a transfer running through it
        blank_in = 1'b1; blink_en = 1'b1;
        repeat (HALF * 3) tick();
        send(16'h3C96, 1, 2, 1);
        repeat (HALF * 2) tick();
        blink_en = 1'b0;
        repeat (4) tick();
        blink_en = 1'b1;
        repeat (HALF * 2 + 3) tick();
        blink_en = 1'b0; blank_in = 1'b0;
        repeat (4) tick();

        summary();
    end

endmodule